// File: doc/BRIEF.md
# Keypad Decimal-to-BCD Priority Encoder

This block turns a row of ten decimal key lines into a 4-bit BCD digit code. Nine of the lines, for the digits one through nine, enter a priority encoder. When more than one of these lines is active, the encoder reports the largest digit among them. Every key line is active low, and the code output is also active low, so the output pins carry the bitwise complement of the BCD value.

No encoder input exists for the digit zero. When none of the nine lines is active, the output encodes BCD zero, and all four pins read high. The zero key line goes around the encoder and only feeds a key-pressed flag. That flag is high whenever any of the ten lines is low, so a pressed zero key can be told apart from an idle keypad.

The block has no clock, no state register and no state machine. Both outputs follow the inputs through combinational logic only. Scanning, debouncing and capture of keys belong to the logic around the block.

Top module: `keypad_bcd_encoder`

## Requirements
- R1: With all ten key lines high, `code_n` reads 4'b1111 and `key_hit` reads 0.
- R2: With only digit line d (1 to 9) low, `code_n` equals the 4-bit complement of d.
- R3: With several digit lines low, `code_n` encodes the largest active digit, and the lower active lines have no effect on it.
- R4: The complement of `code_n` is always a BCD value from 0 to 9.
- R5: The zero key line `zero_key_n` has no effect on `code_n`.
- R6: `key_hit` is 1 exactly when at least one of the ten key lines is low.
- R7: Bit i of `digit_key_n` is the line for digit i+1, so bit 0 is digit 1 and bit 8 is digit 9. Bit 3 of `code_n` is the most significant BCD bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| zero_key_n | input | 1 | Zero key line, active low; drives only the key-pressed flag |
| digit_key_n | input | 9 | Digit key lines 1 to 9, active low; bit i is digit i+1 |
| code_n | output | 4 | Active-low BCD code of the highest active digit |
| key_hit | output | 1 | High when any of the ten key lines is low |

## Verification
The hardest case is the one where priority matters: many lines are active at once and the lower lines must be shown to have no effect. A few chosen patterns would leave most combinations of lower keys untested. The stimulus therefore sweeps all 512 patterns of the nine digit lines, once with the zero key released and once with it pressed. Each pattern is compared against the highest set bit of the inverted input, computed in the bench. Repeating the sweep with the zero line toggled shows, pattern by pattern, that this line can change the flag and never the code.

// File: rtl/keypad_pkg.sv
`timescale 1ns/1ps
package keypad_pkg;
    // Digit lines entering the encoder (digits 1..N_DIGITS).
    localparam int N_DIGITS = 9;
    // Width needed to hold the values 0..N_DIGITS.
    localparam int CODE_W   = $clog2(N_DIGITS + 1);
endpackage

// File: rtl/prio_scan.sv
`timescale 1ns/1ps
// Finds the largest digit whose request bit is set; 0 when none is set.
module prio_scan #(
    parameter int N_REQ = keypad_pkg::N_DIGITS,
    parameter int OUT_W = keypad_pkg::CODE_W
) (
    input  logic [N_REQ-1:0] req,
    output logic [OUT_W-1:0] digit
);
    always_comb begin
        digit = '0;
        for (int i = 0; i < N_REQ; i++) begin
            if (req[i]) digit = OUT_W'(i + 1);
        end
    end

    // R3: the chosen digit is itself requested, and nothing above it is.
    always_comb begin
        if (!$isunknown(req)) begin
            a_r3_winner_active: assert (digit == '0 || req[digit - 1'b1])
                else $error("a_r3_winner_active");
            a_r3_none_higher: assert ((req >> digit) == '0)
                else $error("a_r3_none_higher");
        end
    end
endmodule

// File: rtl/bcd_drive.sv
`timescale 1ns/1ps
// Active-low output stage: one inverter per code bit.
module bcd_drive #(
    parameter int W = keypad_pkg::CODE_W
) (
    input  logic [W-1:0] code,
    output logic [W-1:0] pin_n
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign pin_n[b] = ~code[b];
    end
endmodule

// File: rtl/keypad_bcd_encoder.sv
`timescale 1ns/1ps
module keypad_bcd_encoder (
    input  logic       zero_key_n,
    input  logic [8:0] digit_key_n,
    output logic [3:0] code_n,
    output logic       key_hit
);
    import keypad_pkg::*;

    logic [N_DIGITS-1:0] active;
    logic [CODE_W-1:0]   digit;

    assign active = ~digit_key_n;

    prio_scan #(.N_REQ(N_DIGITS), .OUT_W(CODE_W)) u_scan (
        .req   (active),
        .digit (digit)
    );

    bcd_drive #(.W(CODE_W)) u_drive (
        .code  (digit),
        .pin_n (code_n)
    );

    assign key_hit = ~zero_key_n | (|active);

    always_comb begin
        if (!$isunknown({zero_key_n, digit_key_n})) begin
            // R1: an idle keypad gives all-high pins.
            a_r1_idle: assert (!(&digit_key_n) || code_n == 4'b1111)
                else $error("a_r1_idle");
            // R4: the decoded value never leaves the decimal range.
            a_r4_range: assert (4'(~code_n) <= 4'd9)
                else $error("a_r4_range");
            // R6: a non-zero code always comes with the flag.
            a_r6_flag: assert (code_n == 4'b1111 || key_hit)
                else $error("a_r6_flag");
        end
    end
endmodule

// File: tb/sim_keypad_bcd_encoder.sv
`timescale 1ns/1ps
module sim_keypad_bcd_encoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       zero_key_n;
    logic [8:0] digit_key_n;
    logic [3:0] code_n;
    logic       key_hit;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    always #2.5 clk = ~clk;

    keypad_bcd_encoder u0 (
        .zero_key_n  (zero_key_n),
        .digit_key_n (digit_key_n),
        .code_n      (code_n),
        .key_hit     (key_hit)
    );

    task automatic cmp4(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s zk=%b dk=%b act=%b exp=%b", req, zero_key_n, digit_key_n, act, exp);
        end
    endtask

    task automatic cmp1(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s zk=%b dk=%b act=%b exp=%b", req, zero_key_n, digit_key_n, act, exp);
        end
    endtask

    task automatic apply(input logic zk, input logic [8:0] dk);
        @(posedge clk);
        #1;
        zero_key_n  = zk;
        digit_key_n = dk;
        @(negedge clk);
    endtask

    initial begin
        zero_key_n  = 1'b1;
        digit_key_n = 9'h1FF;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R1: idle state after reset
        @(negedge clk);
        cmp4("R1", code_n, 4'b1111);
        cmp1("R1", key_hit, 1'b0);
        // R2 + R7: each single digit, bit i means digit i+1
        for (int d = 1; d <= 9; d++) begin
            apply(1'b1, ~(9'(1) << (d - 1)));
            cmp4("R2_R7", code_n, ~4'(d));
        end
        // R3, R4, R5, R6: exhaustive sweep with zero key both ways
        for (int z = 0; z < 2; z++) begin
            for (int v = 0; v < 512; v++) begin
                logic [3:0] hi;
                hi = 4'd0;
                for (int b = 0; b < 9; b++) if (v[b]) hi = 4'(b + 1);
                apply(z[0], ~9'(v));
                cmp4(z == 0 ? "R3" : "R5", code_n, ~hi);
                cmp1("R6", key_hit, (v != 0) || (z == 0));
                n_cmp++;
                if (4'(~code_n) > 4'd9) begin
                    n_bad++;
                    $display("FAIL R4 act=%0d exp<=9", 4'(~code_n));
                end
            end
        end
        // R5: zero key alone does not touch the code, but sets the flag
        apply(1'b0, 9'h1FF);
        cmp4("R5", code_n, 4'b1111);
        cmp1("R6", key_hit, 1'b1);
        // R3: top and bottom digit together
        apply(1'b1, 9'b011111110);
        cmp4("R3", code_n, ~4'd9);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule